// File: doc/BRIEF.md
# ADC Output Pattern Test Generator

This block sits just in front of the output drivers of a dual-channel converter. It drives all four 8-bit sample ports (two in-phase, two quadrature) from one register stage. When test mode is off, the converter samples pass through unchanged. When test mode is on, the ports carry a known pattern instead, so a receiver can check the wiring and timing of the output path without any analog input.

The control word comes in as a parallel 10-bit value, as decoded from configuration address 110 by a serial bus decoder outside this block. Bit 0 turns the test function on. Bit 1 picks the kind of pattern: 0 holds a fixed word and 1 runs a counter. Bits 9 down to 2 hold the fixed word. The ports form two pairs. The B pair (BI, BQ) always carries the true pattern: the fixed word, or a counter that counts upward. The A pair (AI, AQ) carries the bitwise complement of the B pair, which in counter mode is a ramp that counts downward.

Top module: `adc_bit_gen`

## Requirements
- R1: While rst_n is low, all four outputs read zero, whatever the control word and conversion inputs are.
- R2: With cfg_word bit 0 at 0, each output equals its own conversion input from one clock earlier. cfg_word bits 9..1 have no effect.
- R3: With bit 0 at 1 and bit 1 at 0 (static), out_bi and out_bq both equal cfg_word[9:2] from one clock earlier, with bit 9 as the MSB.
- R4: In static mode, out_ai and out_aq equal the bitwise NOT of cfg_word[9:2] from one clock earlier.
- R5: With bit 0 at 1 and bit 1 at 1 (dynamic), out_bi and out_bq carry a counter. The counter is 0 in the first output cycle after dynamic mode is selected and rises by 1 in each later cycle.
- R6: The rising ramp wraps from 255 to 0 and keeps counting.
- R7: In dynamic mode, out_ai and out_aq equal 255 minus the rising value, which forms a falling ramp.
- R8: Any cycle outside dynamic mode (disabled or static) returns the counter to 0. The next time dynamic mode is selected, the ramp starts again from 0.
- R9: In both test modes, the conversion inputs have no effect on any output.
- R10: A change of control word takes effect on the outputs after exactly one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_word | input | 10 | Test control word: bit 0 enables test mode, bit 1 selects the mode, bits 9..2 hold the static pattern |
| conv_ai | input | 8 | Conversion data for port AI |
| conv_aq | input | 8 | Conversion data for port AQ |
| conv_bi | input | 8 | Conversion data for port BI |
| conv_bq | input | 8 | Conversion data for port BQ |
| out_ai | output | 8 | Registered output, port AI |
| out_aq | output | 8 | Registered output, port AQ |
| out_bi | output | 8 | Registered output, port BI |
| out_bq | output | 8 | Registered output, port BQ |

## Verification
The hardest situation to reach from the ports is the ramp wrap. Reaching it needs more than 256 unbroken cycles in dynamic mode, and a ramp that starts again correctly after being interrupted is hard to tell apart from one that simply keeps counting. The stimulus first holds dynamic mode for 300 cycles, which crosses the 255-to-0 boundary. It then breaks the run with disabled and static cycles and selects dynamic mode again. A counter that was not cleared would show up as a non-zero first value. Conversion inputs change on every vector, so any leak of them into a test mode gives a mismatch.

// File: rtl/adc_bit_pkg.sv
package adc_bit_pkg;
  localparam int PAT_W    = 8;
  localparam int LANES    = 4;
  localparam int EN_POS   = 0;
  localparam int MODE_POS = 1;
  localparam int PAT_LSB  = 2;

  typedef enum logic [1:0] {
    SRC_CONV   = 2'd0,
    SRC_STATIC = 2'd1,
    SRC_RAMP   = 2'd2
  } src_e;

  function automatic src_e pick_src(input logic en, input logic dyn);
    if (!en) return SRC_CONV;
    return dyn ? SRC_RAMP : SRC_STATIC;
  endfunction

  // A lane carries the inverted pattern when it belongs to the lower half (A pair)
  function automatic logic lane_inverts(input int lane, input int nlanes);
    return lane < (nlanes / 2);
  endfunction
endpackage

// File: rtl/adc_bit_ramp.sv
module adc_bit_ramp #(
  parameter int DW = adc_bit_pkg::PAT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [DW-1:0] cnt
);
  logic live_q;
  logic wrap_evt;

  assign wrap_evt = run && (cnt == {DW{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      live_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
      cnt    <= run ? cnt + 1'b1 : '0;
    end
  end

  // R5: consecutive running cycles step the counter by one
  a_r5_ramp_step: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(run) && !$past(wrap_evt) |-> cnt == $past(cnt) + 1'b1);

  // R6: wrap from all-ones returns to zero
  a_r6_ramp_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(wrap_evt) |-> cnt == '0);
endmodule

// File: rtl/adc_bit_select.sv
module adc_bit_select
  import adc_bit_pkg::*;
#(
  parameter int DW = PAT_W,
  parameter int NL = LANES
) (
  input  src_e                  src,
  input  logic [DW-1:0]         pattern,
  input  logic [DW-1:0]         ramp,
  input  logic [NL-1:0][DW-1:0] conv,
  output logic [NL-1:0][DW-1:0] nxt
);
  for (genvar g = 0; g < NL; g++) begin : g_lane
    localparam bit INV = lane_inverts(g, NL);
    logic [DW-1:0] lane_v;
    always_comb begin
      case (src)
        SRC_STATIC: lane_v = INV ? ~pattern : pattern;
        SRC_RAMP:   lane_v = INV ? ~ramp    : ramp;
        default:    lane_v = conv[g];
      endcase
    end
    assign nxt[g] = lane_v;
  end
endmodule

// File: rtl/adc_bit_outreg.sv
module adc_bit_outreg #(
  parameter int DW = adc_bit_pkg::PAT_W,
  parameter int NL = adc_bit_pkg::LANES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NL-1:0][DW-1:0] d,
  output logic [NL-1:0][DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/adc_bit_gen.sv
module adc_bit_gen
  import adc_bit_pkg::*;
#(
  parameter int DW = PAT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW+1:0] cfg_word,
  input  logic [DW-1:0] conv_ai,
  input  logic [DW-1:0] conv_aq,
  input  logic [DW-1:0] conv_bi,
  input  logic [DW-1:0] conv_bq,
  output logic [DW-1:0] out_ai,
  output logic [DW-1:0] out_aq,
  output logic [DW-1:0] out_bi,
  output logic [DW-1:0] out_bq
);
  localparam int NL = LANES;

  src_e                  src;
  logic [DW-1:0]         pattern;
  logic [DW-1:0]         ramp_cnt;
  logic                  ramp_run;
  logic [NL-1:0][DW-1:0] conv_lanes;
  logic [NL-1:0][DW-1:0] nxt_lanes;
  logic [NL-1:0][DW-1:0] out_lanes;
  logic                  live_q;

  assign src        = pick_src(cfg_word[EN_POS], cfg_word[MODE_POS]);
  assign pattern    = cfg_word[PAT_LSB +: DW];
  assign ramp_run   = (src == SRC_RAMP);
  assign conv_lanes = {conv_bq, conv_bi, conv_aq, conv_ai};

  adc_bit_ramp #(.DW(DW)) u_ramp (
    .clk(clk), .rst_n(rst_n), .run(ramp_run), .cnt(ramp_cnt)
  );

  adc_bit_select #(.DW(DW), .NL(NL)) u_sel (
    .src(src), .pattern(pattern), .ramp(ramp_cnt),
    .conv(conv_lanes), .nxt(nxt_lanes)
  );

  adc_bit_outreg #(.DW(DW), .NL(NL)) u_oreg (
    .clk(clk), .rst_n(rst_n), .d(nxt_lanes), .q(out_lanes)
  );

  assign out_ai = out_lanes[0];
  assign out_aq = out_lanes[1];
  assign out_bi = out_lanes[2];
  assign out_bq = out_lanes[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  // R2 R10: pass-through one clock later
  a_r2_pass: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(src == SRC_CONV) |->
      out_ai == $past(conv_ai) && out_aq == $past(conv_aq) &&
      out_bi == $past(conv_bi) && out_bq == $past(conv_bq));

  // R3: B pair carries the static word
  a_r3_static_b: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(src == SRC_STATIC) |->
      out_bi == $past(pattern) && out_bq == $past(pattern));

  // R4: A pair is the complement of the B pair in static mode
  a_r4_static_a: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(src == SRC_STATIC) |->
      (out_ai ^ out_bi) == {DW{1'b1}} && out_aq == out_ai);

  // R7: ramps sum to all-ones
  a_r7_ramp_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $past(ramp_run) |->
      ({1'b0, out_ai} + {1'b0, out_bi}) == {1'b0, {DW{1'b1}}} &&
      out_aq == out_ai && out_bq == out_bi);

  // R8: entering dynamic mode gives a zero first value
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && $rose(ramp_run) |=> out_bi == '0);
endmodule

// File: tb/adc_bit_gen_tb.sv
module adc_bit_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] cfg;
  logic [7:0] c_ai, c_aq, c_bi, c_bq;
  logic [7:0] o_ai, o_aq, o_bi, o_bq;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  int          n_chk = 0;
  int          n_bad = 0;
  int          ramp_m = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  adc_bit_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg),
    .conv_ai(c_ai), .conv_aq(c_aq), .conv_bi(c_bi), .conv_bq(c_bq),
    .out_ai(o_ai), .out_aq(o_aq), .out_bi(o_bi), .out_bq(o_bq)
  );

  // Driver: one vector per cycle, expected result queued for the next edge
  task automatic apply(input bit en, input bit dyn, input logic [7:0] pat,
                       input logic [31:0] conv, input string tag);
    logic [7:0]  b, a;
    logic [31:0] e;
    @(negedge clk);
    cfg = {pat, dyn, en};
    {c_ai, c_aq, c_bi, c_bq} = conv;
    if (!en) begin
      e = conv; ramp_m = 0;
    end else if (!dyn) begin
      b = pat; a = 8'(255 - int'(pat)); e = {a, a, b, b}; ramp_m = 0;
    end else begin
      b = 8'(ramp_m); a = 8'(255 - ramp_m); e = {a, a, b, b};
      ramp_m = (ramp_m + 1) % 256;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare just after each rising edge
  always begin
    @(posedge clk);
    #1;
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if ({o_ai, o_aq, o_bi, o_bq} !== e) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", t, {o_ai, o_aq, o_bi, o_bq}, e);
      end
    end
  end

  function automatic logic [31:0] mix(input int i);
    return 32'h9E3779B9 * (i + 1) ^ 32'h5A5A0F0F;
  endfunction

  initial begin
    rst_n = 1'b0;
    cfg = {8'h5A, 1'b1, 1'b1};
    {c_ai, c_aq, c_bi, c_bq} = 32'hDEADBEEF;
    repeat (3) @(posedge clk);
    #1;
    n_chk++;  // R1: reset holds zero despite active dynamic config
    if ({o_ai, o_aq, o_bi, o_bq} !== 32'h0) begin
      n_bad++;
      $display("FAIL R1: got %h expected %h", {o_ai, o_aq, o_bi, o_bq}, 32'h0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R2: disabled, mode and pattern bits set to junk
    for (int i = 0; i < 8; i++) apply(1'b0, i[0], 8'(i * 37), mix(i), "R2");
    // R3 R4 R9 R10: static words, conversion data busy
    apply(1'b1, 1'b0, 8'hA5, mix(10), "R3 R4 R9");
    apply(1'b1, 1'b0, 8'h00, mix(11), "R3 R4 R9");
    apply(1'b1, 1'b0, 8'hFF, mix(12), "R3 R4 R9");
    apply(1'b1, 1'b0, 8'h3C, mix(13), "R3 R4 R9");
    apply(1'b0, 1'b0, 8'h3C, mix(14), "R10");
    apply(1'b1, 1'b0, 8'h81, mix(15), "R10");
    // R5 R6 R7 R9: long ramp crossing the wrap
    for (int i = 0; i < 300; i++) apply(1'b1, 1'b1, 8'(i), mix(100 + i), "R5 R6 R7 R9");
    // R8: interrupt with disabled then static, then restart
    apply(1'b0, 1'b1, 8'h11, mix(500), "R8");
    for (int i = 0; i < 4; i++) apply(1'b1, 1'b1, 8'h00, mix(501 + i), "R8 R5");
    apply(1'b1, 1'b0, 8'hC3, mix(510), "R8 R10");
    for (int i = 0; i < 4; i++) apply(1'b1, 1'b1, 8'h77, mix(511 + i), "R8 R7");
    apply(1'b0, 1'b0, 8'h00, mix(520), "R10 R2");

    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule